// File: doc/BRIEF.md
# Stop-clock power state controller

This block moves a processor core between running and a clock-stopped low-power condition under control of an active-low stop request. When the request is seen while the core runs, the block first asks the bus unit for an acknowledge special cycle. It then waits for bus-ready on that cycle, and after that for the write buffer to drain. The drain condition can be overridden by a mask input. Only then does it drop the core clock enable.

While stopped, the block keeps servicing snoop (inquire) cycles. It returns to the stopped condition after each snoop without issuing a second acknowledge cycle. Releasing the request starts a short wake sequence of fixed length that brings the core back to running in fewer than ten cycles. If the request comes back during that wake sequence, a guard makes sure at least one instruction retires before the block stops the core again. A timestamp counter runs in every state. A flush request is passed on only while the core clock is enabled.

States: RUN (normal execution), ACK (special cycle requested, waiting for bus-ready), DRAIN (waiting for write-buffer-empty or mask), GRANT (clock stopped), SNOOP (inquire while stopped), WAKE (exit sequence). Transitions:
- RUN→ACK on a stop request when the guard is clear.
- ACK→DRAIN on bus-ready.
- DRAIN→GRANT on write-buffer-empty or mask.
- GRANT→SNOOP on inquire start.
- SNOOP→GRANT on inquire done.
- GRANT→WAKE on release with no inquire start.
- WAKE→RUN when the wake count reaches `WAKE_CYC`.
- Any state→RUN on reset.

Top module: `stopclk_ctrl`

## Requirements
- R1: Synchronous reset (`rst` high at a clock edge) puts the block in RUN from any state: `spc_req`=0, `core_clk_en`=1, `tsc`=0. It also clears the guard, so a stop request held low across reset leads to `spc_req`=1 one cycle after reset is released.
- R2: In RUN with the guard clear, `stop_req_n`=0 at a clock edge makes `spc_req` 1 from that edge. `spc_req` stays 1 until an edge where `bus_ready`=1 is sampled.
- R3: `spc_req` goes to 0 at the edge that samples `bus_ready`=1. The clock enable drops at a later edge, the first one that samples `wbuf_empty`=1 or `wbuf_mask`=1.
- R4: `core_clk_en` is 0 in GRANT and SNOOP and 1 in RUN, ACK, DRAIN and WAKE.
- R5: In GRANT the block stays stopped while `stop_req_n`=0 and no inquire starts. Reset asserted in GRANT restores `core_clk_en`=1.
- R6: From the edge that samples the release in GRANT, WAKE lasts `WAKE_CYC` cycles (default 4) and RUN is reached at the following edge. A request asserted after RUN is reached is served at once, and RUN is always reached in fewer than 10 cycles.
- R7: If `stop_req_n`=0 is sampled during WAKE, no special cycle is requested in RUN until `insn_retired`=1 has been sampled in RUN. The request is issued at the edge after that.
- R8: `inq_start`=1 in GRANT moves to SNOOP and takes priority over a release in the same cycle. A release during SNOOP is ignored. `inq_done`=1 returns to GRANT with `spc_req` kept at 0, and a release still present then starts WAKE at the next edge.
- R9: `tsc` increases by one at every clock edge without reset, in every state, wrapping at `TSC_W` bits.
- R10: While the clock stays stopped, `spc_req` keeps the value it had when the special cycle completed (0).
- R11: `flush_go` equals `flush_req` whenever `core_clk_en` is 1 and is 0 in GRANT and SNOOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| stop_req_n | input | 1 | Stop-clock request, active low |
| bus_ready | input | 1 | Bus-ready for the special cycle |
| wbuf_empty | input | 1 | Write buffer empty |
| wbuf_mask | input | 1 | Skip the write-buffer-empty wait |
| inq_start | input | 1 | Snoop cycle begins |
| inq_done | input | 1 | Snoop cycle finished |
| insn_retired | input | 1 | One instruction retired this cycle |
| flush_req | input | 1 | Cache flush request |
| spc_req | output | 1 | Acknowledge special bus cycle request |
| core_clk_en | output | 1 | Core clock enable |
| flush_go | output | 1 | Flush request passed to the core |
| tsc | output | TSC_W | Free-running timestamp counter |

## Verification
The bench targets the ordering of the two entry handshakes. A design that gated the clock on bus-ready alone, or that ignored the mask, would stop too early or hang in DRAIN. It sends a release together with an inquire start, and holds a release through a snoop. A wrong priority would wake the core in the middle of a snoop, or would request a second special cycle after it. It re-asserts the request one cycle before and one cycle after RUN is reached. This exposes a wake sequence of the wrong length and a guard that is missing or never clears. It also checks that reset taken with the request held low clears the guard, and that the timestamp and the flush gating behave correctly across the stopped period.

// File: rtl/stopclk_pkg.sv
package stopclk_pkg;

    typedef enum logic [2:0] {
        PS_RUN   = 3'd0,
        PS_ACK   = 3'd1,
        PS_DRAIN = 3'd2,
        PS_GRANT = 3'd3,
        PS_SNOOP = 3'd4,
        PS_WAKE  = 3'd5
    } pstate_e;

endpackage

// File: rtl/stopclk_tsc.sv
module stopclk_tsc #(
    parameter int TSC_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    output logic [TSC_W-1:0] count
);
    // Runs on the ungated clock, so it advances in every power state.
    always_ff @(posedge clk) begin
        if (rst) count <= '0;
        else     count <= count + TSC_W'(1);
    end
endmodule

// File: rtl/stopclk_exit_timer.sv
module stopclk_exit_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             hold,
    output logic [CNT_W-1:0] count
);
    // Loaded on the release edge, advanced through WAKE, cleared otherwise.
    always_ff @(posedge clk) begin
        if (rst)        count <= '0;
        else if (start) count <= CNT_W'(1);
        else if (hold)  count <= count + CNT_W'(1);
        else            count <= '0;
    end
endmodule

// File: rtl/stopclk_fsm.sv
module stopclk_fsm
    import stopclk_pkg::*;
#(
    parameter int WAKE_CYC = 4,
    parameter int CNT_W    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stop_req_n,
    input  logic             bus_ready,
    input  logic             wbuf_empty,
    input  logic             wbuf_mask,
    input  logic             inq_start,
    input  logic             inq_done,
    input  logic             insn_retired,
    input  logic             flush_req,
    input  logic [CNT_W-1:0] wake_cnt,
    output pstate_e          state,
    output logic             guard,
    output logic             release_evt,
    output logic             wake_hold,
    output logic             spc_req,
    output logic             core_clk_en,
    output logic             flush_go
);
    localparam logic [CNT_W-1:0] WAKE_LAST = CNT_W'(WAKE_CYC);

    pstate_e nxt;
    logic    wake_done;

    assign wake_done   = (state == PS_WAKE) && (wake_cnt == WAKE_LAST);
    assign wake_hold   = (state == PS_WAKE) && !wake_done;
    assign release_evt = (state == PS_GRANT) && !inq_start && stop_req_n;

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= PS_RUN;
        else     state <= nxt;
    end

    // One-instruction guard: armed by a request seen during WAKE,
    // cleared by a retirement seen in RUN.
    always_ff @(posedge clk) begin
        if (rst)
            guard <= 1'b0;
        else if (state == PS_WAKE && !stop_req_n)
            guard <= 1'b1;
        else if (state == PS_RUN && insn_retired)
            guard <= 1'b0;
    end

    // Next state
    always_comb begin
        nxt = state;
        unique case (state)
            PS_RUN:   if (!stop_req_n && !guard)     nxt = PS_ACK;
            PS_ACK:   if (bus_ready)                 nxt = PS_DRAIN;
            PS_DRAIN: if (wbuf_empty || wbuf_mask)   nxt = PS_GRANT;
            PS_GRANT: begin
                if (inq_start)       nxt = PS_SNOOP;
                else if (stop_req_n) nxt = PS_WAKE;
            end
            PS_SNOOP: if (inq_done)                  nxt = PS_GRANT;
            PS_WAKE:  if (wake_done)                 nxt = PS_RUN;
            default:                                 nxt = PS_RUN;
        endcase
    end

    // Outputs
    always_comb begin
        spc_req     = 1'b0;
        core_clk_en = 1'b1;
        unique case (state)
            PS_ACK:   spc_req     = 1'b1;
            PS_GRANT: core_clk_en = 1'b0;
            PS_SNOOP: core_clk_en = 1'b0;
            default: begin
                spc_req     = 1'b0;
                core_clk_en = 1'b1;
            end
        endcase
        flush_go = flush_req && core_clk_en;
    end
endmodule

// File: rtl/stopclk_ctrl.sv
module stopclk_ctrl
    import stopclk_pkg::*;
#(
    parameter int TSC_W      = 16,
    parameter int WAKE_CYC   = 4,
    parameter int EXIT_LIMIT = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stop_req_n,
    input  logic             bus_ready,
    input  logic             wbuf_empty,
    input  logic             wbuf_mask,
    input  logic             inq_start,
    input  logic             inq_done,
    input  logic             insn_retired,
    input  logic             flush_req,
    output logic             spc_req,
    output logic             core_clk_en,
    output logic             flush_go,
    output logic [TSC_W-1:0] tsc
);
    localparam int CNT_W = $clog2(EXIT_LIMIT + 1);

    pstate_e          state;
    logic             guard;
    logic             release_evt;
    logic             wake_hold;
    logic [CNT_W-1:0] wake_cnt;

    stopclk_fsm #(
        .WAKE_CYC (WAKE_CYC),
        .CNT_W    (CNT_W)
    ) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .stop_req_n   (stop_req_n),
        .bus_ready    (bus_ready),
        .wbuf_empty   (wbuf_empty),
        .wbuf_mask    (wbuf_mask),
        .inq_start    (inq_start),
        .inq_done     (inq_done),
        .insn_retired (insn_retired),
        .flush_req    (flush_req),
        .wake_cnt     (wake_cnt),
        .state        (state),
        .guard        (guard),
        .release_evt  (release_evt),
        .wake_hold    (wake_hold),
        .spc_req      (spc_req),
        .core_clk_en  (core_clk_en),
        .flush_go     (flush_go)
    );

    stopclk_exit_timer #(
        .CNT_W (CNT_W)
    ) u_exit (
        .clk   (clk),
        .rst   (rst),
        .start (release_evt),
        .hold  (wake_hold),
        .count (wake_cnt)
    );

    stopclk_tsc #(
        .TSC_W (TSC_W)
    ) u_tsc (
        .clk   (clk),
        .rst   (rst),
        .count (tsc)
    );
endmodule

// File: rtl/stopclk_ctrl_chk.sv
module stopclk_ctrl_chk
    import stopclk_pkg::*;
#(
    parameter int TSC_W      = 16,
    parameter int EXIT_LIMIT = 9,
    parameter int CNT_W      = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             stop_req_n,
    input logic             bus_ready,
    input logic             wbuf_empty,
    input logic             wbuf_mask,
    input logic             inq_start,
    input logic             inq_done,
    input logic             insn_retired,
    input logic             spc_req,
    input logic             core_clk_en,
    input logic             flush_go,
    input logic [TSC_W-1:0] tsc,
    input pstate_e          state,
    input logic             guard,
    input logic [CNT_W-1:0] wake_cnt
);
    AST_ACK_HOLD: assert property (@(posedge clk) disable iff (rst)
        spc_req && !bus_ready |=> spc_req); // R2

    AST_ACK_DROP: assert property (@(posedge clk) disable iff (rst)
        spc_req && bus_ready |=> !spc_req); // R3

    AST_GATE_AFTER_DRAIN: assert property (@(posedge clk) disable iff (rst)
        $fell(core_clk_en) |-> $past(wbuf_empty || wbuf_mask) && $past(state == PS_DRAIN)); // R3

    AST_HOLD_IN_GRANT: assert property (@(posedge clk) disable iff (rst)
        (state == PS_GRANT) && !stop_req_n && !inq_start |=> !core_clk_en); // R5

    AST_EXIT_BOUND: assert property (@(posedge clk) disable iff (rst)
        wake_cnt <= CNT_W'(EXIT_LIMIT)); // R6

    AST_GUARD_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        guard && (state == PS_RUN) && !insn_retired |=> !spc_req); // R7

    AST_SNOOP_RETURN: assert property (@(posedge clk) disable iff (rst)
        (state == PS_SNOOP) && inq_done |=> !spc_req && !core_clk_en); // R8

    AST_TSC_STEP: assert property (@(posedge clk) disable iff (rst)
        !core_clk_en || core_clk_en |=> tsc == $past(tsc) + TSC_W'(1)); // R9

    AST_STOPPED_STABLE: assert property (@(posedge clk) disable iff (rst)
        !core_clk_en && $past(!core_clk_en) |-> $stable(spc_req) && !flush_go); // R10
endmodule

bind stopclk_ctrl stopclk_ctrl_chk #(
    .TSC_W      (TSC_W),
    .EXIT_LIMIT (EXIT_LIMIT),
    .CNT_W      (CNT_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .stop_req_n   (stop_req_n),
    .bus_ready    (bus_ready),
    .wbuf_empty   (wbuf_empty),
    .wbuf_mask    (wbuf_mask),
    .inq_start    (inq_start),
    .inq_done     (inq_done),
    .insn_retired (insn_retired),
    .spc_req      (spc_req),
    .core_clk_en  (core_clk_en),
    .flush_go     (flush_go),
    .tsc          (tsc),
    .state        (state),
    .guard        (guard),
    .wake_cnt     (wake_cnt)
);

// File: tb/stopclk_ctrl_tb.sv
module stopclk_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int TSC_W      = 16;
    localparam int WAKE_CYC   = 4;
    localparam int WDOG_MAX   = 5000;
    localparam int NVEC       = 15;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic stop_req_n = 1'b1, bus_ready = 1'b0, wbuf_empty = 1'b0, wbuf_mask = 1'b0;
    logic inq_start = 1'b0, inq_done = 1'b0, insn_retired = 1'b0, flush_req = 1'b0;
    logic spc_req, core_clk_en, flush_go;
    logic [TSC_W-1:0] tsc;

    int n_run  = 0;
    int n_fail = 0;
    int cycles = 0;
    logic [TSC_W-1:0] t0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stopclk_ctrl #(.TSC_W(TSC_W), .WAKE_CYC(WAKE_CYC), .EXIT_LIMIT(9)) u_dut (
        .clk(clk), .rst(rst), .stop_req_n(stop_req_n), .bus_ready(bus_ready),
        .wbuf_empty(wbuf_empty), .wbuf_mask(wbuf_mask), .inq_start(inq_start),
        .inq_done(inq_done), .insn_retired(insn_retired), .flush_req(flush_req),
        .spc_req(spc_req), .core_clk_en(core_clk_en), .flush_go(flush_go), .tsc(tsc)
    );

    // Vector bits: [10] stop_req_n [9] bus_ready [8] wbuf_empty [7] wbuf_mask
    // [6] inq_start [5] inq_done [4] insn_retired [3] flush_req
    // expected after one edge: [2] spc_req [1] core_clk_en [0] flush_go
    localparam logic [10:0] VEC [NVEC] = '{
        11'b1_0_0_0_0_0_0_1_0_1_1,  // RUN, flush passes            R11
        11'b0_0_0_0_0_0_0_0_1_1_0,  // request -> ACK               R2
        11'b0_0_0_0_0_0_0_1_1_1_1,  // no bus-ready, ACK holds      R2
        11'b0_1_0_0_0_0_0_0_0_1_0,  // bus-ready -> DRAIN           R3
        11'b0_0_0_0_0_0_0_0_0_1_0,  // buffer busy, DRAIN holds     R3
        11'b0_0_1_0_0_0_0_0_0_0_0,  // buffer empty -> GRANT        R4
        11'b0_0_0_0_0_0_0_1_0_0_0,  // flush ignored in GRANT       R11
        11'b0_0_0_0_1_0_0_0_0_0_0,  // inquire -> SNOOP             R8
        11'b1_0_0_0_0_0_0_1_0_0_0,  // release ignored in SNOOP     R8
        11'b1_0_0_0_0_1_0_0_0_0_0,  // done -> GRANT, no new ACK    R8
        11'b1_0_0_0_0_0_0_0_0_1_0,  // release -> WAKE              R6
        11'b1_0_0_0_0_0_0_0_0_1_0,
        11'b1_0_0_0_0_0_0_0_0_1_0,
        11'b1_0_0_0_0_0_0_0_0_1_0,
        11'b1_0_0_0_0_0_0_1_0_1_1   // RUN again                    R6
    };

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [10:0] v);
        {stop_req_n, bus_ready, wbuf_empty, wbuf_mask,
         inq_start, inq_done, insn_retired, flush_req} = v[10:3];
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    // Reach GRANT from ACK: bus-ready then buffer empty.
    task automatic ack_to_grant();
        bus_ready = 1'b1; tick(); bus_ready = 1'b0;
        wbuf_empty = 1'b1; tick(); wbuf_empty = 1'b0;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WDOG_MAX) begin
                n_run++; n_fail++;
                $display("FAIL watchdog: actual %0d expected <= %0d cycles", cycles, WDOG_MAX);
                finish_run();
            end
        end
    end

    initial begin
        tick(); tick(); tick();
        // R1 reset state
        chk("R1 spc_req after reset", 32'(spc_req), 32'd0);
        chk("R1 core_clk_en after reset", 32'(core_clk_en), 32'd1);
        chk("R1 tsc after reset", 32'(tsc), 32'd0);
        rst = 1'b0;
        tick();
        chk("R9 tsc first count", 32'(tsc), 32'd1);

        // Vector walk: entry, snoop, release, wake
        for (int i = 0; i < NVEC; i++) begin
            apply(VEC[i]);
            tick();
            chk($sformatf("R2/R3 spc_req row %0d", i), 32'(spc_req), 32'(VEC[i][2]));
            chk($sformatf("R4 core_clk_en row %0d", i), 32'(core_clk_en), 32'(VEC[i][1]));
            chk($sformatf("R11 flush_go row %0d", i), 32'(flush_go), 32'(VEC[i][0]));
        end
        flush_req = 1'b0;

        // R3 mask skips the write-buffer wait
        stop_req_n = 1'b0; tick();
        bus_ready = 1'b1; tick(); bus_ready = 1'b0;
        chk("R3 DRAIN clock on", 32'(core_clk_en), 32'd1);
        wbuf_mask = 1'b1; tick(); wbuf_mask = 1'b0;
        chk("R3 mask enters GRANT", 32'(core_clk_en), 32'd0);

        // R5 / R9 / R10 held stopped, counter keeps running
        t0 = tsc;
        repeat (5) tick();
        chk("R5 still stopped", 32'(core_clk_en), 32'd0);
        chk("R10 spc_req held", 32'(spc_req), 32'd0);
        chk("R9 tsc counts in GRANT", 32'(tsc), 32'(TSC_W'(t0 + TSC_W'(5))));

        // R7 request back during WAKE arms the guard
        stop_req_n = 1'b1;
        repeat (WAKE_CYC) tick();
        stop_req_n = 1'b0;
        tick();
        chk("R7 no request with guard", 32'(spc_req), 32'd0);
        tick(); tick();
        chk("R7 still blocked", 32'(spc_req), 32'd0);
        insn_retired = 1'b1; tick(); insn_retired = 1'b0;
        chk("R7 retire edge", 32'(spc_req), 32'd0);
        tick();
        chk("R7 request after retire", 32'(spc_req), 32'd1);

        // R6 request right after RUN is reached is served at once
        ack_to_grant();
        stop_req_n = 1'b1;
        repeat (WAKE_CYC + 1) tick();
        stop_req_n = 1'b0;
        tick();
        chk("R6 RUN reached in time", 32'(spc_req), 32'd1);

        // R8 inquire wins over a release in the same cycle
        ack_to_grant();
        stop_req_n = 1'b1; inq_start = 1'b1; tick(); inq_start = 1'b0;
        chk("R8 inquire priority", 32'(core_clk_en), 32'd0);
        tick();
        chk("R8 release ignored in SNOOP", 32'(core_clk_en), 32'd0);
        inq_done = 1'b1; tick(); inq_done = 1'b0;
        chk("R8 back to GRANT clk", 32'(core_clk_en), 32'd0);
        chk("R8 no second special cycle", 32'(spc_req), 32'd0);
        tick();
        chk("R8 pending release wakes", 32'(core_clk_en), 32'd1);

        // R1 reset during WAKE with request held clears the guard
        stop_req_n = 1'b0; tick();
        rst = 1'b1; tick();
        chk("R1 reset from WAKE clk", 32'(core_clk_en), 32'd1);
        chk("R1 reset tsc", 32'(tsc), 32'd0);
        rst = 1'b0; tick();
        chk("R1 guard cleared by reset", 32'(spc_req), 32'd1);

        // R5 reset exits GRANT
        ack_to_grant();
        chk("R5 in GRANT", 32'(core_clk_en), 32'd0);
        rst = 1'b1; tick(); rst = 1'b0; stop_req_n = 1'b1;
        chk("R5 reset leaves GRANT", 32'(core_clk_en), 32'd1);
        chk("R5 reset spc_req", 32'(spc_req), 32'd0);
        tick();

        finish_run();
    end
endmodule